// File: doc/BRIEF.md
# Multi-Channel Interrupt Fan-Out Multiplexer

This block takes a set of level-sensitive, active-high interrupt lines and offers every one of them to each of several independent output channels. Each channel holds its own enable mask. A channel raises its single interrupt output while at least one source that it has enabled is high. Software uses the pending view of a channel to find out which of its enabled sources are active.

Every source passes through a two-flop synchroniser before any mask is applied. Each channel has a 64-byte address window on a simple register port. The port carries an address, write data, a write strobe, a read strobe and registered read data. The enable mask sits at offset 0x10 of the window and is read/write. The read-only pending view sits at offset 0x20.

Top module: `irq_fanout_mux`

## Requirements
- R1: There are 8 channels, and each drives one bit of `irq_o`. Any of the 32 sources can reach any channel, and a source asserts only the channels whose mask enables it.
- R2: The enable register of channel n is at byte address 0x10 + 0x40·n. It is read/write and reads back the last value written. Bit i set lets source i contribute to channel n.
- R3: The pending register of channel n is at byte address 0x20 + 0x40·n. Bit i reads as (synchronised source i AND enable bit i). Writes to this register change no state.
- R4: `irq_o[n]` is the OR of channel n's pending bits, registered once. It is never high unless channel n had a non-zero mask in the previous cycle.
- R5: A write replaces only the addressed channel's mask. A read-modify-write that sets one bit changes that bit alone, and it leaves the masks of the other channels unchanged.
- R6: After zero is written to a channel's mask, that channel's output is low in the next cycle, whatever the sources are doing.
- R7: After reset, all masks are zero, `irq_o` is all low and `rdata_o` is zero.
- R8: A source passes through two synchroniser flops. A source that rises between clock edges shows in the pending view after two edges and on `irq_o` after three edges, and `irq_o` is still low after two edges.
- R9: Reads of any other offset in a window, or of channel index 8 or above (address 0x200 and up), return zero. Writes to these addresses change no mask.
- R10: Read data appears on `rdata_o` on the clock edge that samples `rd_en_i` high. A write takes effect on the clock edge that samples `wr_en_i` high.
- R11: Sources are not latched. When a source falls, its pending bit and the channel output follow it back low after the same latency as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Asynchronous level interrupt sources |
| addr_i | input | 12 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 8 | One interrupt output per channel |

## Verification
A register read is due on the edge that samples its strobe. A mask write shows on `irq_o` one edge after the write edge. A source change shows in the pending view after two edges and on `irq_o` after three. The bench drives every input on the falling edge. A driver task queues the expected read data, and a monitor pops it at the falling edge after the edge that sampled the read. Checks of the outputs wait a fixed count of falling edges that follows these latencies. The source-path checks also sample one edge early, to confirm that the output has not yet moved.

// File: rtl/irq_fanout_mux.sv
module irq_fanout_mux #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CH    = 8,
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 64,
  parameter int EN_OFF    = 16,
  parameter int PEND_OFF  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [NUM_SRC-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int OFF_W = $clog2(WIN_BYTES);
  localparam int CH_W  = ADDR_W - OFF_W;
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_SRC-1:0] sync1, sync2;
  logic [NUM_CH-1:0][NUM_SRC-1:0] en_q;

  wire [CH_W-1:0]  ch     = addr_i[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0] off    = addr_i[OFF_W-1:0];
  wire [IDX_W-1:0] ch_idx = ch[IDX_W-1:0];
  wire ch_ok    = 32'(ch) < NUM_CH;
  wire hit_en   = ch_ok && (off == OFF_W'(EN_OFF));
  wire hit_pend = ch_ok && (off == OFF_W'(PEND_OFF));

  wire [NUM_SRC-1:0] rd_val = hit_en   ? en_q[ch_idx] :
                              hit_pend ? (sync2 & en_q[ch_idx]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= src_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_o <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_en_i && hit_en && ch_idx == IDX_W'(c))
          en_q[c] <= wdata_i;
        irq_o[c] <= |(sync2 & en_q[c]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_o <= '0;
    else if (rd_en_i)
      rdata_o <= rd_val;
  end
endmodule

// File: rtl/irq_fanout_mux_chk.sv
module irq_fanout_mux_chk #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_CH    = 8,
  parameter int ADDR_W    = 12,
  parameter int WIN_BYTES = 64,
  parameter int EN_OFF    = 16,
  parameter int PEND_OFF  = 32
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [NUM_SRC-1:0]             wdata_i,
  input logic                           wr_en_i,
  input logic                           rd_en_i,
  input logic [NUM_SRC-1:0]             rdata_o,
  input logic [NUM_CH-1:0]              irq_o,
  input logic [NUM_CH-1:0][NUM_SRC-1:0] en_q
);
  localparam int OFF_W = $clog2(WIN_BYTES);

  logic mapped;
  always_comb begin
    mapped = 1'b0;
    for (int c = 0; c < NUM_CH; c++)
      if (addr_i == ADDR_W'(EN_OFF + WIN_BYTES * c) ||
          addr_i == ADDR_W'(PEND_OFF + WIN_BYTES * c))
        mapped = 1'b1;
  end

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && !mapped) |=> rdata_o == '0);

  p_pend_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i[OFF_W-1:0] == OFF_W'(PEND_OFF)) |=> $stable(en_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == ADDR_W'(EN_OFF + WIN_BYTES * c)) |=> en_q[c] == $past(wdata_i));

    p_irq_needs_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> $past(en_q[c] != '0));

    p_zero_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[c] == '0) |=> !irq_o[c]);
  end
endmodule

bind irq_fanout_mux irq_fanout_mux_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
  .WIN_BYTES(WIN_BYTES), .EN_OFF(EN_OFF), .PEND_OFF(PEND_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o),
  .irq_o(irq_o), .en_q(en_q)
);

// File: tb/irq_fanout_mux_test.sv
module irq_fanout_mux_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  irq_fanout_mux uut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] en_addr(int n);
    return 12'(16 + 64 * n);
  endfunction
  function automatic logic [11:0] pend_addr(int n);
    return 12'(32 + 64 * n);
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      if (rd_en_i) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10: unexpected read, actual %h expected none", rdata_o);
        end else begin
          item_t it;
          it = sb.pop_front();
          check(rdata_o, it.exp, it.tag);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    check({24'd0, irq_o}, 32'd0, "R7 irq after reset");
    check(rdata_o, 32'd0, "R7 rdata after reset");
    rst_n = 1'b1;
    @(negedge clk);
    rd(en_addr(0), 32'd0, "R7 mask zero after reset");

    wr(en_addr(0), 32'h0000_0001);
    rd(en_addr(0), 32'h0000_0001, "R2 mask readback");

    src_i[0] = 1'b1;
    repeat (2) @(negedge clk);
    check({24'd0, irq_o}, 32'd0, "R8 irq not yet after two edges");
    @(negedge clk);
    check({24'd0, irq_o}, 32'h01, "R8 R1 irq0 only after three edges");
    rd(pend_addr(0), 32'h0000_0001, "R3 pending ch0");
    rd(pend_addr(1), 32'h0000_0000, "R1 pending ch1 masked");

    wr(pend_addr(0), 32'hFFFF_FFFF);
    rd(en_addr(0), 32'h0000_0001, "R3 pending write ignored (mask)");
    rd(pend_addr(0), 32'h0000_0001, "R3 pending write ignored (pending)");

    wr(en_addr(3), 32'hA5A5_0000);
    rd(en_addr(3), 32'hA5A5_0000, "R5 ch3 mask before rmw");
    wr(en_addr(3), 32'hA5A5_0008);
    rd(en_addr(3), 32'hA5A5_0008, "R5 ch3 mask after rmw");
    rd(en_addr(0), 32'h0000_0001, "R5 ch0 mask untouched");

    src_i[3] = 1'b1;
    repeat (3) @(negedge clk);
    check({24'd0, irq_o}, 32'h09, "R1 ch3 raised by source 3");
    rd(pend_addr(3), 32'h0000_0008, "R3 pending ch3");

    src_i[0] = 1'b0;
    repeat (2) @(negedge clk);
    check({24'd0, irq_o}, 32'h09, "R11 irq0 still high after two edges");
    @(negedge clk);
    check({24'd0, irq_o}, 32'h08, "R11 irq0 follows source low");
    rd(pend_addr(0), 32'h0000_0000, "R11 pending ch0 cleared");

    addr_i = en_addr(3); wdata_i = 32'd0; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
    check({24'd0, irq_o}, 32'h08, "R10 irq unchanged at write edge");
    @(negedge clk);
    check({24'd0, irq_o}, 32'h00, "R6 zero mask clears irq3");

    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h014, 32'd0, "R9 unmapped offset reads zero");
    wr(12'h210, 32'hFFFF_FFFF);
    rd(12'h210, 32'd0, "R9 channel 8 reads zero");
    rd(en_addr(0), 32'h0000_0001, "R9 unmapped writes leave ch0");
    rd(en_addr(3), 32'h0000_0000, "R9 unmapped writes leave ch3");

    wr(en_addr(7), 32'h8000_0000);
    src_i[31] = 1'b1;
    repeat (3) @(negedge clk);
    check({24'd0, irq_o}, 32'h80, "R1 top channel, top source");
    rd(pend_addr(7), 32'h8000_0008 & 32'h8000_0000, "R3 pending ch7");
    rd(en_addr(7), 32'h8000_0000, "R10 read data one edge after strobe");

    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL R10: actual %0d reads outstanding expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule